// File: doc/BRIEF.md
# Reversible Step-Tracking Counter

This block is the digital back end of a counter-type tracking converter. A comparator upstream sends two separate strobe lines: one fires for each quantization step the analog input climbs, the other for each step it drops. The block keeps the net number of steps as an unsigned binary count. The count is the converted sample. It can be read on a parallel output at any moment, and reading it never pauses or delays the tracking.

The counter is built as an increment-style ripple chain. A rising step injects a one at the least significant stage, and the carry ripples upward. A falling step injects a one into every stage at the same time. That adds the all-ones word, which is minus one in two's complement, so one adder performs both directions. The count wraps modulo 2^COUNT_W. Every wrap sets a sticky flag. A synchronous load sets the count to a chosen starting code, for example mid-scale.

Each cycle, a decoder sorts the inputs into one command: CMD_HOLD, CMD_INC, CMD_DEC or CMD_LOAD. A load takes priority over both strobes. Two strobes together, or no strobe at all, give CMD_HOLD. The wrap flag is a two-state machine with states FLAG_CLEAN and FLAG_WRAPPED:
- FLAG_CLEAN goes to FLAG_WRAPPED on a wrap event.
- FLAG_WRAPPED goes to FLAG_CLEAN on a clear request with no wrap in the same cycle.
- Every other case stays in the current state.

Top module: `step_tally_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, the count reads the mid-scale code 8'h80 and the wrap flag reads 0.
- R2: An up strobe alone, with no load, makes the count exactly one greater on the next cycle.
- R3: A down strobe alone, with no load, makes the count exactly one smaller on the next cycle.
- R4: Up and down strobes in the same cycle cancel, and the count is unchanged on the next cycle.
- R5: With no strobe and no load, the count holds its value.
- R6: The count wraps modulo 256. An up strobe at 8'hFF gives 8'h00, a down strobe at 8'h00 gives 8'hFF, and either event sets the wrap flag on the next cycle.
- R7: The wrap flag stays at 1 until a clear request. A clear request drives the flag to 0 on the next cycle, except when a wrap happens in the same cycle: then the flag stays at 1.
- R8: A load sets the count to the supplied value on the next cycle. Strobes in that cycle are ignored, and the load does not change the wrap flag.
- R9: Strobes in consecutive cycles each take effect. The count output changes every such cycle, with no stall or skipped step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up | input | 1 | One-cycle strobe: input rose one quantization step |
| step_down | input | 1 | One-cycle strobe: input fell one quantization step |
| preset_en | input | 1 | Synchronous load of the starting code |
| preset_code | input | COUNT_W | Code loaded when preset_en is high |
| wrap_clear | input | 1 | Synchronous clear request for the wrap flag |
| level_out | output | COUNT_W | Registered count, readable continuously |
| wrap_seen | output | 1 | Sticky flag, set by any overflow or underflow |

## Verification
The assertions assume that the two strobes are single-cycle and are sampled only on rising edges. They also assume that a load in a cycle overrides both strobes. With that, every cycle can be judged against the value the count had one cycle before.

The stimulus changes inputs only at the falling edge, so each cycle presents one settled combination of strobe, load and clear. It includes:
- directed runs to the two wrap boundaries;
- a clear that coincides with a wrap;
- back-to-back strobes;
- a long random stretch in which loads and clears are rare.

In the random stretch the count walks freely across both ends of the range.

// File: rtl/step_pkg.sv
package step_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_INC  = 2'd1,
        CMD_DEC  = 2'd2,
        CMD_LOAD = 2'd3
    } step_cmd_t;

    typedef enum logic {
        FLAG_CLEAN   = 1'b0,
        FLAG_WRAPPED = 1'b1
    } flag_state_t;

endpackage

// File: rtl/step_decoder.sv
module step_decoder
    import step_pkg::*;
(
    input  logic      up_i,
    input  logic      down_i,
    input  logic      load_i,
    output step_cmd_t cmd_o
);

    always_comb begin
        unique case ({load_i, up_i, down_i})
            3'b000:  cmd_o = CMD_HOLD;
            3'b010:  cmd_o = CMD_INC;
            3'b001:  cmd_o = CMD_DEC;
            3'b011:  cmd_o = CMD_HOLD;   // opposite steps cancel
            default: cmd_o = CMD_LOAD;   // load overrides strobes
        endcase
    end

    always_comb begin
        a_r8_load_priority: assert (!load_i || cmd_o == CMD_LOAD)
            else $error("load did not win over strobes");
    end

endmodule

// File: rtl/ripple_cell.sv
module ripple_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    assign s_o = a_i ^ b_i ^ c_i;
    assign c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));

endmodule

// File: rtl/step_accumulator.sv
module step_accumulator
    import step_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  step_cmd_t          cmd_i,
    input  logic [COUNT_W-1:0] preset_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               wrap_o
);

    localparam logic [COUNT_W-1:0] MID_CODE = COUNT_W'(1) << (COUNT_W - 1);
    localparam logic [COUNT_W-1:0] ONE_CODE = COUNT_W'(1);

    logic [COUNT_W-1:0] addend;
    logic [COUNT_W-1:0] sum;
    logic [COUNT_W:0]   carry;
    logic [COUNT_W-1:0] count_q;

    // Rising step enters at stage 0 only; falling step enters every stage.
    always_comb begin
        unique case (cmd_i)
            CMD_INC: addend = ONE_CODE;
            CMD_DEC: addend = '1;
            default: addend = '0;
        endcase
    end

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < COUNT_W; g++) begin : g_stage
        ripple_cell u_cell (
            .a_i (count_q[g]),
            .b_i (addend[g]),
            .c_i (carry[g]),
            .s_o (sum[g]),
            .c_o (carry[g+1])
        );
    end

    // Carry out on increment means overflow; missing carry on decrement means underflow.
    always_comb begin
        unique case (cmd_i)
            CMD_INC: wrap_o = carry[COUNT_W];
            CMD_DEC: wrap_o = ~carry[COUNT_W];
            default: wrap_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= MID_CODE;
        end else begin
            unique case (cmd_i)
                CMD_LOAD: count_q <= preset_i;
                CMD_HOLD: count_q <= count_q;
                default:  count_q <= sum;
            endcase
        end
    end

    assign count_o = count_q;

    a_r2_inc_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_INC |=> count_q == COUNT_W'($past(count_q) + ONE_CODE));

    a_r3_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_DEC |=> count_q == COUNT_W'($past(count_q) - ONE_CODE));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_HOLD |=> $stable(count_q));

    a_r6_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_INC && count_q == '1) |-> wrap_o);

    a_r6_bottom_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_DEC && count_q == '0) |-> wrap_o);

endmodule

// File: rtl/wrap_flag_fsm.sv
module wrap_flag_fsm
    import step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic clear_i,
    output logic flag_o
);

    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_CLEAN:   state_d = wrap_i ? FLAG_WRAPPED : FLAG_CLEAN;
            FLAG_WRAPPED: state_d = (clear_i && !wrap_i) ? FLAG_CLEAN : FLAG_WRAPPED;
            default:      state_d = FLAG_CLEAN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLAG_WRAPPED: flag_o = 1'b1;
            default:      flag_o = 1'b0;
        endcase
    end

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clear_i) |=> flag_o);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !wrap_i) |=> !flag_o);

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o);

endmodule

// File: rtl/step_tally_top.sv
module step_tally_top
    import step_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_up,
    input  logic               step_down,
    input  logic               preset_en,
    input  logic [COUNT_W-1:0] preset_code,
    input  logic               wrap_clear,
    output logic [COUNT_W-1:0] level_out,
    output logic               wrap_seen
);

    step_cmd_t cmd;
    logic      wrap_evt;

    step_decoder u_dec (
        .up_i   (step_up),
        .down_i (step_down),
        .load_i (preset_en),
        .cmd_o  (cmd)
    );

    step_accumulator #(.COUNT_W(COUNT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .preset_i (preset_code),
        .count_o  (level_out),
        .wrap_o   (wrap_evt)
    );

    wrap_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap_evt),
        .clear_i (wrap_clear),
        .flag_o  (wrap_seen)
    );

    a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && step_down && !preset_en) |=> $stable(level_out));

    a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        preset_en |=> level_out == $past(preset_code));

    a_r8_load_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_en && !wrap_clear) |=> wrap_seen == $past(wrap_seen));

endmodule

// File: tb/step_tally_top_test.sv
module step_tally_top_test;

    localparam int W = 8;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_up = 1'b0;
    logic         step_down = 1'b0;
    logic         preset_en = 1'b0;
    logic [W-1:0] preset_code = '0;
    logic         wrap_clear = 1'b0;
    logic [W-1:0] level_out;
    logic         wrap_seen;

    int checks = 0;
    int fails = 0;
    int ref_count = MOD / 2;
    bit ref_flag = 1'b0;
    bit done = 1'b0;

    logic [W-1:0] exp_cnt[$];
    bit           exp_flg[$];
    string        exp_tag[$];
    string        exp_ftag[$];

    always #4 clk = ~clk;   // 125 MHz

    step_tally_top #(.COUNT_W(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_up     (step_up),
        .step_down   (step_down),
        .preset_en   (preset_en),
        .preset_code (preset_code),
        .wrap_clear  (wrap_clear),
        .level_out   (level_out),
        .wrap_seen   (wrap_seen)
    );

    task automatic drive(input bit u, input bit d, input bit ld,
                         input logic [W-1:0] v, input bit clr, input string forced);
        string tag;
        string ftag;
        bit    wrap;
        @(negedge clk);
        step_up = u; step_down = d; preset_en = ld; preset_code = v; wrap_clear = clr;
        wrap = 1'b0;
        if (ld) begin
            ref_count = int'(v);
            tag = "R8";
        end else if (u && d) begin
            tag = "R4";
        end else if (u) begin
            wrap = (ref_count == MOD - 1);
            ref_count = (ref_count + 1) % MOD;
            tag = wrap ? "R6" : "R2";
        end else if (d) begin
            wrap = (ref_count == 0);
            ref_count = (ref_count + MOD - 1) % MOD;
            tag = wrap ? "R6" : "R3";
        end else begin
            tag = "R5";
        end
        if (wrap)      ref_flag = 1'b1;
        else if (clr)  ref_flag = 1'b0;
        ftag = wrap ? "R6" : (clr ? "R7" : (ld ? "R8" : "R7"));
        if (forced != "") begin
            tag = forced;
            ftag = forced;
        end
        exp_cnt.push_back(W'(ref_count));
        exp_flg.push_back(ref_flag);
        exp_tag.push_back(tag);
        exp_ftag.push_back(ftag);
    endtask

    // Monitor: compares one cycle after each driven vector, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_cnt.size() > 0) begin
                logic [W-1:0] ec;
                bit           ef;
                string        et;
                string        eft;
                ec = exp_cnt.pop_front();
                ef = exp_flg.pop_front();
                et = exp_tag.pop_front();
                eft = exp_ftag.pop_front();
                checks++;
                if (level_out !== ec || wrap_seen !== ef) begin
                    fails++;
                    if (level_out !== ec)
                        $display("FAIL %s: level_out=%02h expected %02h", et, level_out, ec);
                    else
                        $display("FAIL %s: wrap_seen=%0b expected %0b", eft, wrap_seen, ef);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        checks++;
        if (level_out !== 8'h80 || wrap_seen !== 1'b0) begin
            fails++;
            $display("FAIL R1: level_out=%02h flag=%0b expected 80/0", level_out, wrap_seen);
        end
        rst_n = 1'b1;
        drive(0, 0, 0, 8'h00, 0, "R1");          // first cycle after reset: still mid-scale

        drive(1, 0, 0, 8'h00, 0, "");            // R2
        drive(1, 0, 0, 8'h00, 0, "");
        drive(1, 0, 0, 8'h00, 0, "");
        drive(0, 1, 0, 8'h00, 0, "");            // R3
        drive(0, 1, 0, 8'h00, 0, "");
        drive(1, 1, 0, 8'h00, 0, "");            // R4
        drive(0, 0, 0, 8'h00, 0, "");            // R5

        drive(0, 0, 1, 8'hFE, 0, "");            // R8
        drive(1, 0, 0, 8'h00, 0, "");            // FE->FF
        drive(1, 0, 0, 8'h00, 0, "");            // R6 FF->00, flag set
        drive(0, 0, 0, 8'h00, 0, "R7");          // flag sticky
        drive(0, 0, 0, 8'h00, 0, "R7");
        drive(0, 0, 0, 8'h00, 1, "R7");          // clear
        drive(1, 1, 1, 8'h00, 0, "R8");          // load 00, strobes ignored
        drive(0, 1, 0, 8'h00, 0, "");            // R6 00->FF
        drive(0, 0, 1, 8'h10, 0, "R8");          // load keeps flag
        drive(0, 0, 1, 8'hFF, 1, "R7");          // clear while loading
        drive(1, 0, 0, 8'h00, 1, "R7");          // wrap wins over clear
        drive(0, 0, 0, 8'h00, 1, "R7");

        for (int i = 0; i < 12; i++) drive(1, 0, 0, 8'h00, 0, "R9");
        for (int i = 0; i < 12; i++) drive(i[0], !i[0], 0, 8'h00, 0, "R9");
        for (int i = 0; i < 12; i++) drive(0, 1, 0, 8'h00, 0, "R9");

        for (int i = 0; i < 3000; i++) begin
            int r;
            bit ld;
            bit clr;
            r = int'($urandom_range(0, 99));
            ld = (r < 2);
            clr = (int'($urandom_range(0, 99)) < 3);
            drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ld,
                  W'($urandom_range(0, MOD - 1)), clr, "");
        end

        drive(0, 0, 0, 8'h00, 0, "");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule